// File: doc/BRIEF.md
# Dual-Clock FIFO with Configurable Pointer Resets

This block is a small first-in first-out buffer whose write side and read side run on unrelated clocks. The pointer positions cross between the two domains as gray code through two-flop synchronizers. The full, almost-full, empty and almost-empty flags are derived from these crossed pointers. The read side is show-ahead: `rddata` always presents the entry at the read pointer, and a pulse on `rden` advances past it.

Two user reset inputs, `wrrst` and `rdrst`, each have their own active level. Each pointer has its own reset path, configured by parameters. A source parameter chooses whether the path responds to `wrrst` only, `rdrst` only, or either input. A mode parameter chooses whether the input acts directly as a synchronous reset or first passes through an internal synchronizer. A depth parameter sets the number of synchronizer stages. The synchronizer asserts at once and releases on the destination clock. Because the two paths are independent, the read pointer can be reset on its own so that stored data is read again.

After a reset ends, `wr_ready` tells the writer when the first write may be issued. It rises only after the write side has waited its stage count plus three write clocks and the read side has waited its stage count plus three read clocks.

Top module: `dcfifo_rstcfg`

## Requirements
- R1: The reset level of `wrrst` is set by `WRST_LVL` and that of `rdrst` by `RDRST_LVL`; by default `wrrst` is active when 1 and `rdrst` is active when 0. With source "either", driving `rdrst` alone to its active level resets both pointers, so a full FIFO reports `full` = 0.
- R2: While both reset inputs are held active, `empty` and `almost_empty` are 1 no later than `RPTR_STAGES`+2 rising `rdclk` edges after the assertion.
- R3: While both reset inputs are held active, `full` and `almost_full` are 0 no later than `WPTR_STAGES`+2 rising `wrclk` edges after the assertion.
- R4: `wr_ready` is 0 while the write pointer is in reset. After release it stays 0 for at least max((`WPTR_STAGES`+3) `wrclk` periods, (`RPTR_STAGES`+3) `rdclk` periods), then rises.
- R5: A `wren` or `rden` pulse during reset moves no pointer and stores nothing. After release the FIFO is empty, and the next written word is the next word read.
- R6: Words are read out in the order they were written.
- R7: With 2^`AW` words stored, `full` is 1 and further writes are dropped.
- R8: With no words stored, `empty` is 1 and a read changes nothing.
- R9: `almost_full` is 1 when the stored count seen by the write side is at least `AFULL_TH` (default 6). `almost_empty` is 1 when the count seen by the read side is at most `AEMPTY_TH` (default 2).
- R10: With the read pointer set to respond to `rdrst` only, a pulse on `rdrst` returns reading to the oldest stored word and leaves the write pointer untouched. The same words are then read again, and new writes append after them.
- R11: In direct mode, a pointer reset takes effect at the first rising edge of that pointer's clock that samples the input active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrclk | input | 1 | Write-side clock |
| wrrst | input | 1 | Write-side user reset, level set by WRST_LVL |
| wren | input | 1 | Write request |
| wrdata | input | DW | Data to store |
| full | output | 1 | No space left |
| almost_full | output | 1 | Stored count at or above AFULL_TH |
| wr_ready | output | 1 | Post-reset wait complete; writes may start |
| rdclk | input | 1 | Read-side clock |
| rdrst | input | 1 | Read-side user reset, level set by RDRST_LVL |
| rden | input | 1 | Read request (pops the shown word) |
| rddata | output | DW | Word at the read pointer |
| empty | output | 1 | Nothing stored |
| almost_empty | output | 1 | Stored count at or below AEMPTY_TH |

## Verification
The bench first fills the FIFO. It then asserts both resets while write and read requests are held high, and samples the flags right at the stated edge bound. A design that lets requests through during reset would leave data behind after release, and a slow synchronizer would miss the bound. The release wait is measured in write clocks against both domain limits, so a ready signal that ignores the slower read side rises too early. A second instance with direct, per-side sources rewinds only the read pointer after two reads. A design that also cleared the write pointer, or delayed a direct reset, would return the wrong word or lose the appended one. The bench also exercises overflow and underflow attempts and the almost-full and almost-empty thresholds at their exact counts.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
    // which user reset inputs drive a pointer reset
    typedef enum logic [1:0] {
        SRC_WR  = 2'd0,
        SRC_RD  = 2'd1,
        SRC_ANY = 2'd2
    } rst_src_e;

    // direct synchronous use, or internal assert-async/release-sync stage chain
    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_SYNC   = 1'b1
    } rst_mode_e;
endpackage

// File: rtl/dcfifo_rst_path.sv
module dcfifo_rst_path
    import dcfifo_pkg::*;
#(
    parameter rst_src_e    SRC    = SRC_ANY,
    parameter rst_mode_e   MODE   = MODE_SYNC,
    parameter int unsigned STAGES = 2,
    parameter logic        WR_LVL = 1'b1,
    parameter logic        RD_LVL = 1'b1
) (
    input  logic clk,
    input  logic wrrst,
    input  logic rdrst,
    output logic rst_o
);
    logic wr_act;
    logic rd_act;
    logic raw;

    assign wr_act = (wrrst == WR_LVL);
    assign rd_act = (rdrst == RD_LVL);

    always_comb begin
        case (SRC)
            SRC_WR:  raw = wr_act;
            SRC_RD:  raw = rd_act;
            default: raw = wr_act | rd_act;
        endcase
    end

    generate
        if (MODE == MODE_SYNC) begin : g_sync
            logic [STAGES-1:0] chain_d;
            logic [STAGES-1:0] chain_q;

            always_comb chain_d = chain_q << 1;

            // entry is immediate, exit walks through STAGES edges of clk
            always_ff @(posedge clk or posedge raw) begin
                if (raw) chain_q <= '1;
                else     chain_q <= chain_d;
            end

            assign rst_o = chain_q[STAGES-1];
        end else begin : g_direct
            assign rst_o = raw;
        end
    endgenerate
endmodule

// File: rtl/dcfifo_bus_sync.sv
module dcfifo_bus_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d;
    sync_t sync_q;

    always_comb begin
        sync_d.s1 = clr ? '0 : d;
        sync_d.s2 = clr ? '0 : sync_q.s1;
    end

    always_ff @(posedge clk) sync_q <= sync_d;

    assign q = sync_q.s2;
endmodule

// File: rtl/dcfifo_side.sv
module dcfifo_side #(
    parameter int unsigned AW     = 3,
    parameter bit          IS_WR  = 1'b1,
    parameter int unsigned TH     = 2,
    parameter int unsigned SETTLE = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic [AW:0] far_gray,
    output logic [AW:0] ptr_bin,
    output logic [AW:0] ptr_gray,
    output logic        flag,
    output logic        almost,
    output logic        fire,
    output logic        settled
);
    localparam int unsigned CW       = $clog2(SETTLE + 1);
    localparam logic [AW:0] FULL_LVL = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] TH_V     = (AW + 1)'(TH);
    localparam logic [CW-1:0] SET_V  = CW'(SETTLE);

    typedef struct packed {
        logic [AW:0]   bin;
        logic [AW:0]   gray;
        logic [CW-1:0] cnt;
    } side_t;

    side_t side_d;
    side_t side_q;
    logic [AW:0] far_bin;
    logic [AW:0] level;

    always_comb begin
        far_bin[AW] = far_gray[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            far_bin[i] = far_bin[i+1] ^ far_gray[i];
        end
    end

    generate
        if (IS_WR) begin : g_wr
            assign level  = side_q.bin - far_bin;
            assign flag   = (level == FULL_LVL);
            assign almost = (level >= TH_V);
        end else begin : g_rd
            assign level  = far_bin - side_q.bin;
            assign flag   = (level == '0);
            assign almost = (level <= TH_V);
        end
    endgenerate

    assign fire = req & ~flag & ~rst;

    always_comb begin
        side_d = side_q;
        if (rst) begin
            side_d = '0;
        end else begin
            if (fire) begin
                side_d.bin  = side_q.bin + 1'b1;
                side_d.gray = side_d.bin ^ (side_d.bin >> 1);
            end
            if (side_q.cnt != SET_V) side_d.cnt = side_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) side_q <= side_d;

    assign ptr_bin  = side_q.bin;
    assign ptr_gray = side_q.gray;
    assign settled  = (side_q.cnt == SET_V);
endmodule

// File: rtl/dcfifo_rstcfg.sv
module dcfifo_rstcfg
    import dcfifo_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned AW          = 3,
    parameter int unsigned AFULL_TH    = 6,
    parameter int unsigned AEMPTY_TH   = 2,
    parameter logic        WRST_LVL    = 1'b1,
    parameter logic        RDRST_LVL   = 1'b0,
    parameter rst_src_e    WPTR_SRC    = SRC_ANY,
    parameter rst_mode_e   WPTR_MODE   = MODE_SYNC,
    parameter int unsigned WPTR_STAGES = 3,
    parameter rst_src_e    RPTR_SRC    = SRC_ANY,
    parameter rst_mode_e   RPTR_MODE   = MODE_SYNC,
    parameter int unsigned RPTR_STAGES = 2
) (
    input  logic          wrclk,
    input  logic          wrrst,
    input  logic          wren,
    input  logic [DW-1:0] wrdata,
    output logic          full,
    output logic          almost_full,
    output logic          wr_ready,
    input  logic          rdclk,
    input  logic          rdrst,
    input  logic          rden,
    output logic [DW-1:0] rddata,
    output logic          empty,
    output logic          almost_empty
);
    localparam int unsigned DEPTH = 1 << AW;

    logic          wr_rst;
    logic          rd_rst;
    logic [AW:0]   w_bin;
    logic [AW:0]   w_gray;
    logic [AW:0]   r_bin;
    logic [AW:0]   r_gray;
    logic [AW:0]   rgray_w;
    logic [AW:0]   wgray_r;
    logic          w_fire;
    logic          r_fire;
    logic          w_settled;
    logic          r_settled;
    logic          r_settled_w;
    logic [DW-1:0] mem_q [DEPTH];

    dcfifo_rst_path #(
        .SRC(WPTR_SRC), .MODE(WPTR_MODE), .STAGES(WPTR_STAGES),
        .WR_LVL(WRST_LVL), .RD_LVL(RDRST_LVL)
    ) u_wr_rst (
        .clk(wrclk), .wrrst(wrrst), .rdrst(rdrst), .rst_o(wr_rst)
    );

    dcfifo_rst_path #(
        .SRC(RPTR_SRC), .MODE(RPTR_MODE), .STAGES(RPTR_STAGES),
        .WR_LVL(WRST_LVL), .RD_LVL(RDRST_LVL)
    ) u_rd_rst (
        .clk(rdclk), .wrrst(wrrst), .rdrst(rdrst), .rst_o(rd_rst)
    );

    dcfifo_side #(
        .AW(AW), .IS_WR(1'b1), .TH(AFULL_TH), .SETTLE(WPTR_STAGES + 3)
    ) u_wside (
        .clk(wrclk), .rst(wr_rst), .req(wren), .far_gray(rgray_w),
        .ptr_bin(w_bin), .ptr_gray(w_gray), .flag(full), .almost(almost_full),
        .fire(w_fire), .settled(w_settled)
    );

    dcfifo_side #(
        .AW(AW), .IS_WR(1'b0), .TH(AEMPTY_TH), .SETTLE(RPTR_STAGES + 3)
    ) u_rside (
        .clk(rdclk), .rst(rd_rst), .req(rden), .far_gray(wgray_r),
        .ptr_bin(r_bin), .ptr_gray(r_gray), .flag(empty), .almost(almost_empty),
        .fire(r_fire), .settled(r_settled)
    );

    dcfifo_bus_sync #(.W(AW + 1)) u_r2w (
        .clk(wrclk), .clr(wr_rst), .d(r_gray), .q(rgray_w)
    );

    dcfifo_bus_sync #(.W(AW + 1)) u_w2r (
        .clk(rdclk), .clr(rd_rst), .d(w_gray), .q(wgray_r)
    );

    dcfifo_bus_sync #(.W(1)) u_rdy (
        .clk(wrclk), .clr(wr_rst), .d(r_settled), .q(r_settled_w)
    );

    assign wr_ready = w_settled & r_settled_w;

    always_ff @(posedge wrclk) begin
        if (w_fire) mem_q[w_bin[AW-1:0]] <= wrdata;
    end

    assign rddata = mem_q[r_bin[AW-1:0]];
endmodule

// File: rtl/dcfifo_rstcfg_chk.sv
module dcfifo_rstcfg_chk #(
    parameter int unsigned AW        = 3,
    parameter int unsigned W_STG     = 3,
    parameter int unsigned R_STG     = 2,
    parameter logic        WRST_LVL  = 1'b1,
    parameter logic        RDRST_LVL = 1'b0
) (
    input logic        wrclk,
    input logic        rdclk,
    input logic        wrrst,
    input logic        rdrst,
    input logic        wr_rst,
    input logic        rd_rst,
    input logic        wren,
    input logic        r_fire,
    input logic        full,
    input logic        almost_full,
    input logic        empty,
    input logic        almost_empty,
    input logic        wr_ready,
    input logic [AW:0] wptr,
    input logic [AW:0] rptr
);
    localparam logic [7:0] R_LIM = 8'(R_STG + 2);
    localparam logic [7:0] W_LIM = 8'(W_STG + 2);

    logic       both_act;
    logic [7:0] rd_cnt = '0;
    logic [7:0] wr_cnt = '0;
    logic       arm_w  = 1'b0;
    logic       arm_r  = 1'b0;

    assign both_act = (wrrst == WRST_LVL) && (rdrst == RDRST_LVL);

    always_ff @(posedge rdclk) begin
        if (!both_act)            rd_cnt <= '0;
        else if (rd_cnt != 8'hFF) rd_cnt <= rd_cnt + 1'b1;
        if (rd_rst)               arm_r  <= 1'b1;
    end

    always_ff @(posedge wrclk) begin
        if (!both_act)            wr_cnt <= '0;
        else if (wr_cnt != 8'hFF) wr_cnt <= wr_cnt + 1'b1;
        if (wr_rst)               arm_w  <= 1'b1;
    end

    p_empty_on_rst_r2: assert property (@(posedge rdclk) disable iff (!both_act)
        (rd_cnt >= R_LIM) |-> (empty && almost_empty));

    p_full_clear_r3: assert property (@(posedge wrclk) disable iff (!both_act)
        (wr_cnt >= W_LIM) |-> (!full && !almost_full));

    p_ready_low_r4: assert property (@(posedge wrclk) disable iff (!arm_w)
        wr_rst |=> !wr_ready);

    p_wptr_held_r5: assert property (@(posedge wrclk) disable iff (!arm_w)
        wr_rst |=> (wptr == '0));

    p_rptr_held_r5: assert property (@(posedge rdclk) disable iff (!arm_r)
        rd_rst |=> (rptr == '0));

    p_no_overflow_r7: assert property (@(posedge wrclk) disable iff (wr_rst)
        (full && wren) |=> (wptr == $past(wptr)));

    p_no_underflow_r8: assert property (@(posedge rdclk) disable iff (rd_rst)
        empty |-> !r_fire);

    p_pop_step_r6: assert property (@(posedge rdclk) disable iff (rd_rst)
        r_fire |=> (rptr == $past(rptr) + 1'b1));

    p_af_cover_r9: assert property (@(posedge wrclk) disable iff (wr_rst)
        full |-> almost_full);

    p_ae_cover_r9: assert property (@(posedge rdclk) disable iff (rd_rst)
        empty |-> almost_empty);
endmodule

bind dcfifo_rstcfg dcfifo_rstcfg_chk #(
    .AW(AW), .W_STG(WPTR_STAGES), .R_STG(RPTR_STAGES),
    .WRST_LVL(WRST_LVL), .RDRST_LVL(RDRST_LVL)
) u_chk (
    .wrclk(wrclk), .rdclk(rdclk), .wrrst(wrrst), .rdrst(rdrst),
    .wr_rst(wr_rst), .rd_rst(rd_rst), .wren(wren), .r_fire(r_fire),
    .full(full), .almost_full(almost_full), .empty(empty),
    .almost_empty(almost_empty), .wr_ready(wr_ready),
    .wptr(w_bin), .rptr(r_bin)
);

// File: tb/test_dcfifo_rstcfg.sv
module test_dcfifo_rstcfg;
    import dcfifo_pkg::*;

    localparam int WST = 3;
    localparam int RST_STG = 2;
    localparam int WPER = 10;
    localparam int RPER = 14;

    logic wrclk = 1'b0;
    logic rdclk = 1'b0;
    always #(WPER/2) wrclk = ~wrclk;
    always #(RPER/2) rdclk = ~rdclk;

    // instance A: default configuration, rdrst active-low
    logic       a_wrrst = 1'b0, a_rdrst = 1'b1, a_wren = 1'b0, a_rden = 1'b0;
    logic [7:0] a_wrdata = '0, a_rddata;
    logic       a_full, a_af, a_ready, a_empty, a_ae;

    // instance B: direct resets, write pointer on wrrst only, read pointer on rdrst only
    logic       b_wrrst = 1'b0, b_rdrst = 1'b0, b_wren = 1'b0, b_rden = 1'b0;
    logic [7:0] b_wrdata = '0, b_rddata;
    logic       b_full, b_af, b_ready, b_empty, b_ae;

    dcfifo_rstcfg i_dcfifo_rstcfg (
        .wrclk(wrclk), .wrrst(a_wrrst), .wren(a_wren), .wrdata(a_wrdata),
        .full(a_full), .almost_full(a_af), .wr_ready(a_ready),
        .rdclk(rdclk), .rdrst(a_rdrst), .rden(a_rden), .rddata(a_rddata),
        .empty(a_empty), .almost_empty(a_ae)
    );

    dcfifo_rstcfg #(
        .RDRST_LVL(1'b1),
        .WPTR_SRC(SRC_WR), .WPTR_MODE(MODE_DIRECT),
        .RPTR_SRC(SRC_RD), .RPTR_MODE(MODE_DIRECT)
    ) i_dcfifo_rstcfg_rr (
        .wrclk(wrclk), .wrrst(b_wrrst), .wren(b_wren), .wrdata(b_wrdata),
        .full(b_full), .almost_full(b_af), .wr_ready(b_ready),
        .rdclk(rdclk), .rdrst(b_rdrst), .rden(b_rden), .rddata(b_rddata),
        .empty(b_empty), .almost_empty(b_ae)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic a_push(input logic [7:0] d);
        @(negedge wrclk); a_wren = 1'b1; a_wrdata = d;
        @(negedge wrclk); a_wren = 1'b0;
    endtask

    task automatic a_pop(output logic [7:0] d);
        @(negedge rdclk); d = a_rddata; a_rden = 1'b1;
        @(negedge rdclk); a_rden = 1'b0;
    endtask

    task automatic b_push(input logic [7:0] d);
        @(negedge wrclk); b_wren = 1'b1; b_wrdata = d;
        @(negedge wrclk); b_wren = 1'b0;
    endtask

    task automatic b_pop(output logic [7:0] d);
        @(negedge rdclk); d = b_rddata; b_rden = 1'b1;
        @(negedge rdclk); b_rden = 1'b0;
    endtask

    task automatic a_wait_ready();
        for (int i = 0; i < 80 && !a_ready; i++) @(negedge wrclk);
    endtask

    task automatic t_reset_state();
        repeat (6) @(negedge wrclk);
        chk(a_empty == 1'b1, "R2 empty in reset", a_empty, 1);
        chk(a_ae == 1'b1, "R2 almost_empty in reset", a_ae, 1);
        chk(a_full == 1'b0, "R3 full in reset", a_full, 0);
        chk(a_af == 1'b0, "R3 almost_full in reset", a_af, 0);
        chk(a_ready == 1'b0, "R4 wr_ready in reset", a_ready, 0);
    endtask

    task automatic t_release_wait();
        int cyc = 0;
        int min_ns;
        @(negedge wrclk);
        a_wrrst = 1'b0; a_rdrst = 1'b1;
        b_wrrst = 1'b0; b_rdrst = 1'b0;
        while (!a_ready && cyc < 60) begin
            @(negedge wrclk);
            cyc++;
        end
        min_ns = ((WST + 3) * WPER > (RST_STG + 3) * RPER) ? (WST + 3) * WPER : (RST_STG + 3) * RPER;
        chk(cyc * WPER >= min_ns, "R4 ready not early", cyc * WPER, min_ns);
        chk(cyc < 40, "R4 ready rises", cyc, 40);
    endtask

    task automatic t_order();
        logic [7:0] d;
        for (int i = 0; i < 5; i++) a_push(8'h11 * (i + 1));
        repeat (4) @(negedge rdclk);
        chk(a_empty == 1'b0, "R6 not empty after writes", a_empty, 0);
        for (int i = 0; i < 5; i++) begin
            a_pop(d);
            chk(d == 8'(8'h11 * (i + 1)), "R6 order", d, 8'h11 * (i + 1));
        end
    endtask

    task automatic t_full_empty();
        logic [7:0] d;
        for (int i = 0; i < 5; i++) a_push(8'hA0 + 8'(i));
        chk(a_af == 1'b0, "R9 almost_full below threshold", a_af, 0);
        a_push(8'hA5);
        chk(a_af == 1'b1, "R9 almost_full at threshold", a_af, 1);
        chk(a_full == 1'b0, "R7 not full at 6", a_full, 0);
        a_push(8'hA6);
        a_push(8'hA7);
        chk(a_full == 1'b1, "R7 full at depth", a_full, 1);
        a_push(8'hEE);
        a_push(8'hEF);
        chk(a_full == 1'b1, "R7 still full", a_full, 1);
        repeat (4) @(negedge rdclk);
        chk(a_ae == 1'b0, "R9 almost_empty when full", a_ae, 0);
        for (int i = 0; i < 8; i++) begin
            a_pop(d);
            chk(d == 8'hA0 + 8'(i), "R7 data kept, overflow dropped", d, 8'hA0 + i);
            if (i == 4) chk(a_ae == 1'b0, "R9 almost_empty at 3", a_ae, 0);
            if (i == 5) chk(a_ae == 1'b1, "R9 almost_empty at 2", a_ae, 1);
        end
        chk(a_empty == 1'b1, "R8 empty after drain", a_empty, 1);
        a_pop(d);
        a_pop(d);
        a_push(8'h77);
        repeat (4) @(negedge rdclk);
        a_pop(d);
        chk(d == 8'h77, "R8 read on empty ignored", d, 8'h77);
        chk(a_empty == 1'b1, "R8 empty again", a_empty, 1);
    endtask

    task automatic t_reset_entry();
        logic [7:0] d;
        for (int i = 0; i < 8; i++) a_push(8'hC0 + 8'(i));
        chk(a_full == 1'b1, "R2 setup full", a_full, 1);
        @(negedge wrclk);
        a_wrrst = 1'b1; a_rdrst = 1'b0;
        a_wren = 1'b1; a_wrdata = 8'h99; a_rden = 1'b1;
        repeat (RST_STG + 2) @(posedge rdclk);
        #1;
        chk(a_empty == 1'b1, "R2 empty bound", a_empty, 1);
        chk(a_ae == 1'b1, "R2 almost_empty bound", a_ae, 1);
        @(negedge wrclk);
        repeat (WST + 2) @(posedge wrclk);
        #1;
        chk(a_full == 1'b0, "R3 full bound", a_full, 0);
        chk(a_af == 1'b0, "R3 almost_full bound", a_af, 0);
        chk(a_ready == 1'b0, "R4 ready low in reset", a_ready, 0);
        @(negedge wrclk);
        a_wren = 1'b0; a_rden = 1'b0;
        a_wrrst = 1'b0; a_rdrst = 1'b1;
        a_wait_ready();
        repeat (4) @(negedge rdclk);
        chk(a_empty == 1'b1, "R5 requests in reset ignored", a_empty, 1);
        a_push(8'h42);
        repeat (4) @(negedge rdclk);
        a_pop(d);
        chk(d == 8'h42, "R5 pointers unmoved", d, 8'h42);
    endtask

    task automatic t_level();
        for (int i = 0; i < 8; i++) a_push(8'h50 + 8'(i));
        chk(a_full == 1'b1, "R1 setup full", a_full, 1);
        @(negedge wrclk);
        a_rdrst = 1'b0;
        repeat (6) @(negedge wrclk);
        chk(a_full == 1'b0, "R1 active-low rdrst resets", a_full, 0);
        a_rdrst = 1'b1;
        a_wait_ready();
        repeat (4) @(negedge rdclk);
        chk(a_empty == 1'b1, "R1 empty after rdrst", a_empty, 1);
    endtask

    task automatic t_reread();
        logic [7:0] d;
        for (int i = 0; i < 80 && !b_ready; i++) @(negedge wrclk);
        b_push(8'hD1); b_push(8'hD2); b_push(8'hD3);
        repeat (4) @(negedge rdclk);
        b_pop(d); chk(d == 8'hD1, "R10 first read", d, 8'hD1);
        b_pop(d); chk(d == 8'hD2, "R10 second read", d, 8'hD2);
        @(negedge rdclk);
        b_rdrst = 1'b1;
        @(posedge rdclk);
        #1;
        chk(b_rddata == 8'hD1, "R11 direct reset on first edge", b_rddata, 8'hD1);
        @(negedge rdclk);
        b_rdrst = 1'b0;
        repeat (4) @(negedge rdclk);
        for (int i = 0; i < 3; i++) begin
            b_pop(d);
            chk(d == 8'hD1 + 8'(i), "R10 re-read", d, 8'hD1 + i);
        end
        b_push(8'hD4);
        repeat (4) @(negedge rdclk);
        b_pop(d);
        chk(d == 8'hD4, "R10 write pointer kept", d, 8'hD4);
        chk(b_empty == 1'b1, "R10 empty at end", b_empty, 1);
    endtask

    initial begin
        #1;
        a_wrrst = 1'b1; a_rdrst = 1'b0;
        b_wrrst = 1'b1; b_rdrst = 1'b1;
        t_reset_state();
        t_release_wait();
        t_order();
        t_full_empty();
        t_reset_entry();
        t_level();
        t_reread();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge wrclk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule